// File: doc/BRIEF.md
# Serial Command and Configuration Port for a Three-Channel Receiver

This block is the control front end of a three-channel receiver. A host sends it 16-bit serial words. Chip select frames each word, and each bit is sampled on a rising serial clock edge. The block oversamples `cs_n_i`, `sclk_i` and `sdio_i` with the system clock and rebuilds each word. It then either runs a single-word command or accesses one of eight 9-bit configuration registers. Its outputs are the per-channel clamp enables, the sleep state, a one-cycle soft-reset strobe and the AGC hold flag. The channels, the AGC loop and the modulation transistors sit outside the block.

The frame state machine has five states. IDLE goes to HEADER when chip select falls. HEADER returns to IDLE when chip select rises. After the seventh rising edge, HEADER goes to RDATA if the word is a read, and to WDATA otherwise. WDATA and RDATA go to CHECK when chip select rises. CHECK goes back to IDLE and releases the word for execution only if exactly 16 edges were seen. A second state machine holds the power mode, ACTIVE or SLEEP. A sleep command moves it from ACTIVE to SLEEP. Any executed command other than sleep and soft reset moves it from SLEEP back to ACTIVE.

Word layout, most significant bit first, with bit 15 sent first:
- Bits 15:13 carry the command: 0 clamp on, 1 clamp off, 2 sleep, 3 soft reset, 4 hold on, 5 hold off, 6 read, 7 write.
- Bits 12:9 carry the address. Only bits 11:9 select the register.
- Bits 8:0 carry the data, with the row parity bit in bit 0.

Top module: `afe_ctrl_spi`

## Requirements
- R1: A word is 16 bits sent MSb first, laid out as described above, and is executed only after chip select rises. Its effects appear within 6 system clocks of chip select rising.
- R2: Clamp on sets `clamp_o[i]` to register 0 bit i+1, for i = 0..2. Clamp enables that are clear in register 0 stay low.
- R3: Clamp off clears every bit of `clamp_o`, whatever the enables in register 0.
- R4: Sleep sets `sleep_o`. Any other executed command except soft reset clears it, including clamp off, hold on/off, read and write.
- R5: Soft reset produces a one-cycle `soft_rst_o` pulse only when the mode is ACTIVE. In SLEEP it has no effect. It leaves `clamp_o` and `agc_hold_o` unchanged, and it clears the status parity-error bit.
- R6: Hold on sets `agc_hold_o`. Hold off clears it.
- R7: Registers 0 to 6 reset to 9'h001 and read back what was last written to them with odd parity.
- R8: A write with an even number of ones leaves the target register unchanged and sets status bit 1. That bit stays set until a soft reset or a hardware reset.
- R9: Register 7 is read-only. It reads {chan_stat_i[2:0], 3'b000, 1'b0, parity-error, 1'b0} in bits 8:0, and writes to it are discarded.
- R10: On a read, `sdio_oe_o` is low up to the seventh rising edge. On the falling edges that follow, the register bits are shifted out MSb first.
- R11: A word cut short by chip select rising before the 16th edge executes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial read data |
| sdio_oe_o | output | 1 | Read data driver enable |
| chan_stat_i | input | 3 | Channel status, shown in register 7 |
| clamp_o | output | 3 | Per-channel clamp enables |
| sleep_o | output | 1 | Sleep mode active |
| soft_rst_o | output | 1 | One-cycle soft-reset strobe |
| agc_hold_o | output | 1 | AGC level hold mode |

## Verification
The three serial inputs pass through a two-flop synchronizer and an edge detector. The CHECK state follows, then one registered execution stage, so a command's outputs settle within about 6 clocks of chip select rising. The bench waits 12 clocks after chip select rises before it samples any output. Read bits appear about 4 clocks after a falling serial clock edge, and the bench samples each one 8 clocks later, just before the next rising edge. Soft-reset pulses last one cycle, so the bench counts them at every clock edge and compares the count after each word.

// File: rtl/afe_spi_pkg.sv
package afe_spi_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CMD_W      = 3;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 9;
    localparam int NREG       = 8;
    localparam int REG_AW     = $clog2(NREG);
    localparam int NCH        = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_CLAMP_ON  = 3'd0,
        CMD_CLAMP_OFF = 3'd1,
        CMD_SLEEP     = 3'd2,
        CMD_SOFT_RST  = 3'd3,
        CMD_HOLD_ON   = 3'd4,
        CMD_HOLD_OFF  = 3'd5,
        CMD_READ      = 3'd6,
        CMD_WRITE     = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HEADER, ST_WDATA, ST_RDATA, ST_CHECK
    } frame_st_e;

    typedef enum logic {
        MODE_ACTIVE, MODE_SLEEP
    } mode_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/afe_spi_sync.sv
module afe_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdio_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_n_s,
    output logic sdio_s
);
    localparam logic [2:0] RST_VAL = 3'b010; // {sclk, cs_n, sdio}

    logic [2:0] pipe [STAGES];
    logic       sclk_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pipe[g] <= RST_VAL;
                else if (g == 0)
                    pipe[g] <= {sclk_i, cs_n_i, sdio_i};
                else
                    pipe[g] <= pipe[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pipe[STAGES-1][2];
    end

    assign cs_n_s    = pipe[STAGES-1][1];
    assign sdio_s    = pipe[STAGES-1][0];
    assign sclk_rise =  pipe[STAGES-1][2] & ~sclk_d;
    assign sclk_fall = ~pipe[STAGES-1][2] &  sclk_d;
endmodule

// File: rtl/afe_spi_frame.sv
module afe_spi_frame
    import afe_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_n_s,
    input  logic              sdio_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              frame_valid,
    output frame_t            frame_o,
    output logic              sdio_o,
    output logic              sdio_oe_o
);
    localparam int HDR_BITS = CMD_W + ADDR_W;
    localparam int CNT_W    = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);

    frame_st_e             state, nxt;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] shreg, shift_nx;
    logic [DATA_W-1:0]     rd_sh;
    logic                  hdr_done, shifting;

    assign shift_nx = {shreg[FRAME_BITS-2:0], sdio_s};
    assign hdr_done = (state == ST_HEADER) && sclk_rise && (cnt == CNT_HDR);
    assign rd_addr  = shift_nx[REG_AW-1:0];
    assign shifting = (state == ST_HEADER) || (state == ST_WDATA) || (state == ST_RDATA);
    assign frame_o  = frame_t'(shreg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_n_s) nxt = ST_HEADER;
            ST_HEADER: begin
                if (cs_n_s)
                    nxt = ST_IDLE;
                else if (hdr_done)
                    nxt = (cmd_e'(shift_nx[HDR_BITS-1 -: CMD_W]) == CMD_READ) ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA:  if (cs_n_s) nxt = ST_CHECK;
            ST_RDATA:  if (cs_n_s) nxt = ST_CHECK;
            ST_CHECK:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            rd_sh <= '0;
        end else begin
            if (state == ST_IDLE)
                cnt <= '0;
            else if (shifting && sclk_rise && cnt != CNT_SAT)
                cnt <= cnt + 1'b1;
            if (shifting && sclk_rise)
                shreg <= shift_nx;
            if (hdr_done)
                rd_sh <= rd_data;
            else if (state == ST_RDATA && sclk_fall)
                rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            sdio_o      <= 1'b0;
            sdio_oe_o   <= 1'b0;
        end else begin
            frame_valid <= (state == ST_CHECK) && (cnt == CNT_FULL);
            if (state == ST_RDATA && !cs_n_s && sclk_fall) begin
                sdio_o    <= rd_sh[DATA_W-1];
                sdio_oe_o <= 1'b1;
            end else if (state != ST_RDATA) begin
                sdio_o    <= 1'b0;
                sdio_oe_o <= 1'b0;
            end
        end
    end

    // R10
    oe_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe_o) |-> $past(state == ST_RDATA && sclk_fall));

    // R11
    exec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(state == ST_CHECK) && $past(cnt) == CNT_FULL);
endmodule

// File: rtl/afe_cfg_regs.sv
module afe_cfg_regs
    import afe_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_perr,
    input  logic [NCH-1:0]    chan_stat_i,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    chan_en
);
    localparam int NSTORE = NREG - 1;
    localparam logic [DATA_W-1:0] REG_RST = DATA_W'(1);
    localparam logic [REG_AW-1:0] STAT_A  = REG_AW'(NREG - 1);

    logic [DATA_W-1:0] regs [NSTORE];
    logic              perr;
    logic [DATA_W-1:0] status;
    logic              wr_ok;

    assign wr_ok = wr_en && (wr_addr != STAT_A) && (^wr_data);

    genvar g;
    generate
        for (g = 0; g < NSTORE; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= REG_RST;
                else if (wr_ok && wr_addr == REG_AW'(g))
                    regs[g] <= wr_data;
            end
            // R7
            odd_row_chk: assert property (@(posedge clk) disable iff (!rst_n) ^regs[g]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            perr <= 1'b0;
        else if (clr_perr)
            perr <= 1'b0;
        else if (wr_en && wr_addr != STAT_A && !(^wr_data))
            perr <= 1'b1;
    end

    assign status  = {chan_stat_i, {(DATA_W-NCH-2){1'b0}}, perr, 1'b0};
    assign rd_data = (rd_addr == STAT_A) ? status : regs[rd_addr];

    for (genvar c = 0; c < NCH; c++) begin : g_en
        assign chan_en[c] = regs[0][c+1];
    end

    // R8
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(perr) && !$past(clr_perr) |-> perr);
endmodule

// File: rtl/afe_cmd_ctrl.sv
module afe_cmd_ctrl
    import afe_spi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_valid,
    input  cmd_e           cmd_i,
    input  logic [NCH-1:0] chan_en_i,
    output logic [NCH-1:0] clamp_o,
    output logic           sleep_o,
    output logic           soft_rst_o,
    output logic           agc_hold_o
);
    mode_e mode, mode_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_ACTIVE;
        else        mode <= mode_nx;
    end

    always_comb begin
        mode_nx = mode;
        if (frame_valid) begin
            unique case (cmd_i)
                CMD_SLEEP:    mode_nx = MODE_SLEEP;
                CMD_SOFT_RST: mode_nx = mode;
                default:      mode_nx = MODE_ACTIVE;
            endcase
        end
    end

    assign sleep_o = (mode == MODE_SLEEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clamp_o    <= '0;
            soft_rst_o <= 1'b0;
            agc_hold_o <= 1'b0;
        end else begin
            soft_rst_o <= 1'b0;
            if (frame_valid) begin
                unique case (cmd_i)
                    CMD_CLAMP_ON:  clamp_o    <= chan_en_i;
                    CMD_CLAMP_OFF: clamp_o    <= '0;
                    CMD_SOFT_RST:  soft_rst_o <= (mode == MODE_ACTIVE);
                    CMD_HOLD_ON:   agc_hold_o <= 1'b1;
                    CMD_HOLD_OFF:  agc_hold_o <= 1'b0;
                    default:       ;
                endcase
            end
        end
    end

    // R2
    clamp_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_o & ~$past(clamp_o) & ~$past(chan_en_i)) == '0);

    // R5
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R5
    srst_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> !sleep_o && $stable(clamp_o) && $stable(agc_hold_o));
endmodule

// File: rtl/afe_ctrl_spi.sv
module afe_ctrl_spi
    import afe_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n_i,
    input  logic           sclk_i,
    input  logic           sdio_i,
    output logic           sdio_o,
    output logic           sdio_oe_o,
    input  logic [NCH-1:0] chan_stat_i,
    output logic [NCH-1:0] clamp_o,
    output logic           sleep_o,
    output logic           soft_rst_o,
    output logic           agc_hold_o
);
    logic              sclk_rise, sclk_fall, cs_n_s, sdio_s;
    logic              frame_valid;
    frame_t            frame;
    logic [REG_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [NCH-1:0]    chan_en;
    logic              wr_en;

    afe_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdio_i(sdio_i),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_n_s(cs_n_s), .sdio_s(sdio_s)
    );

    afe_spi_frame u_frame (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_n_s(cs_n_s), .sdio_s(sdio_s), .rd_data(rd_data), .rd_addr(rd_addr),
        .frame_valid(frame_valid), .frame_o(frame), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o)
    );

    assign wr_en = frame_valid && (frame.cmd == CMD_WRITE);

    afe_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(frame.addr[REG_AW-1:0]),
        .wr_data(frame.data), .clr_perr(soft_rst_o), .chan_stat_i(chan_stat_i),
        .rd_addr(rd_addr), .rd_data(rd_data), .chan_en(chan_en)
    );

    afe_cmd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .cmd_i(frame.cmd),
        .chan_en_i(chan_en), .clamp_o(clamp_o), .sleep_o(sleep_o),
        .soft_rst_o(soft_rst_o), .agc_hold_o(agc_hold_o)
    );
endmodule

// File: tb/sim_afe_ctrl_spi.sv
module sim_afe_ctrl_spi;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdio = 1'b0;
    logic       sdio_o, sdio_oe;
    logic [2:0] chan_stat = 3'b110;
    logic [2:0] clamp;
    logic       sleep, srst, hold;

    int checks = 0;
    int errors = 0;
    int srst_cnt = 0;
    logic oe_before, oe_after;

    always #5 clk = ~clk;

    afe_ctrl_spi u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdio_i(sdio),
        .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .chan_stat_i(chan_stat),
        .clamp_o(clamp), .sleep_o(sleep), .soft_rst_o(srst), .agc_hold_o(hold)
    );

    always @(posedge clk) if (srst) srst_cnt <= srst_cnt + 1;

    // {word[15:0], clamp[2:0], sleep, hold, soft-reset pulses}
    localparam int NVEC = 12;
    localparam logic [21:0] VEC [NVEC] = '{
        {16'hE00B, 3'b000, 1'b0, 1'b0, 1'b0},  // enable ch0, ch2
        {16'h0000, 3'b101, 1'b0, 1'b0, 1'b0},  // clamp on
        {16'h6000, 3'b101, 1'b0, 1'b0, 1'b1},  // soft reset keeps clamp
        {16'h4000, 3'b101, 1'b1, 1'b0, 1'b0},  // sleep
        {16'h6000, 3'b101, 1'b1, 1'b0, 1'b0},  // soft reset ignored asleep
        {16'h2000, 3'b000, 1'b0, 1'b0, 1'b0},  // clamp off wakes
        {16'h8000, 3'b000, 1'b0, 1'b1, 1'b0},  // hold on
        {16'h4000, 3'b000, 1'b1, 1'b1, 1'b0},  // sleep
        {16'hA000, 3'b000, 1'b0, 1'b0, 1'b0},  // hold off wakes
        {16'hE004, 3'b000, 1'b0, 1'b0, 1'b0},  // enable ch1 only
        {16'h0000, 3'b010, 1'b0, 1'b0, 1'b0},  // clamp on
        {16'h6000, 3'b010, 1'b0, 1'b0, 1'b1}   // soft reset
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, output logic [8:0] rd);
        rd = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdio = w[15-i];
            repeat (4) @(negedge clk);
            if (i == 6) oe_before = sdio_oe;
            if (i == 7) oe_after  = sdio_oe;
            if (i >= 7) rd = {rd[7:0], sdio_o};
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] rd;
        int         base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7 reset state
        chk("R7 reset outputs", {10'b0, clamp, sleep, srst, hold, sdio_oe}, 16'h0);
        xfer(16'hC600, 16, rd);
        chk("R7 reg3 default", {7'b0, rd}, 16'h0001);
        chk("R10 oe low in header", {15'b0, oe_before}, 16'h0);
        chk("R10 oe high in data", {15'b0, oe_after}, 16'h1);

        // R1 R2 R3 R4 R5 R6 vector walk
        for (int v = 0; v < NVEC; v++) begin
            base = srst_cnt;
            xfer(VEC[v][21:6], 16, rd);
            chk("R1 R2 R3 clamp", {13'b0, clamp}, {13'b0, VEC[v][5:3]});
            chk("R4 sleep", {15'b0, sleep}, {15'b0, VEC[v][2]});
            chk("R6 hold", {15'b0, hold}, {15'b0, VEC[v][1]});
            chk("R5 soft reset pulses", 16'(srst_cnt - base), {15'b0, VEC[v][0]});
        end

        // R7 write and read back
        xfer(16'hE6A7, 16, rd);
        xfer(16'hC600, 16, rd);
        chk("R7 reg3 readback", {7'b0, rd}, 16'h00A7);

        // R8 even parity write rejected
        xfer(16'hE6A6, 16, rd);
        xfer(16'hC600, 16, rd);
        chk("R8 reg3 unchanged", {7'b0, rd}, 16'h00A7);
        xfer(16'hCE00, 16, rd);
        chk("R8 R9 status perr", {7'b0, rd}, 16'h0182);

        // R9 status write discarded
        xfer(16'hEE7F, 16, rd);
        xfer(16'hCE00, 16, rd);
        chk("R9 status read-only", {7'b0, rd}, 16'h0182);

        // R11 aborted write
        xfer(16'hE601, 10, rd);
        xfer(16'hC600, 16, rd);
        chk("R11 abort no write", {7'b0, rd}, 16'h00A7);
        xfer(16'h4000, 12, rd);
        chk("R11 abort no sleep", {15'b0, sleep}, 16'h0);

        // R5 soft reset clears parity error
        xfer(16'h6000, 16, rd);
        chan_stat = 3'b011;
        xfer(16'hCE00, 16, rd);
        chk("R5 perr cleared", {7'b0, rd}, 16'h00C0);

        // R4 read wakes from sleep
        xfer(16'h4000, 16, rd);
        chk("R4 asleep", {15'b0, sleep}, 16'h1);
        xfer(16'hC000, 16, rd);
        chk("R4 read wakes", {15'b0, sleep}, 16'h0);
        chk("R7 reg0 readback", {7'b0, rd}, 16'h0004);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule